// File: doc/BRIEF.md
# Line Driver Output Enable Controller

This block decides when the transmit line driver and the other device outputs may leave high impedance. The line driver is held off until three conditions are met. The reference clock must be reported present. A run of transmit clock edges must have been seen since the reference clock appeared. The active four-bit driver configuration code must not be the high-impedance code.

The block runs in one of two modes. In hardware mode the configuration code comes straight from pins. In host mode it comes from an internal register that software writes. Reset loads that register with the high-impedance code, so software has to write a usable code before the driver can turn on.

Two power-down controls give a board-test tristate. When both are high, every output is released in hardware mode. In host mode the same setting releases every output except the processor-interface data outputs. All enables are registered on the transmit clock, so none of them can glitch.

Top module: `line_oe_ctrl`

## Requirements
- R1: While `rst_n` is low, `drv_en`, `aux_en` and `dio_en` are 0, the edge count is 0 and the host configuration register holds 4'b1111.
- R2: With a usable code and no power-down, `drv_en` goes high on the 4th consecutive `tx_clk` rising edge at which `ref_present` is sampled high, and not on any earlier edge.
- R3: An edge at which `ref_present` is sampled low clears the count and drops `drv_en` at that edge. Four new edges with `ref_present` high are then needed before `drv_en` returns.
- R4: The count saturates at four. `drv_en` stays high for as long as `ref_present` stays high, with no wrap.
- R5: The code 4'b1111 means high impedance, and `drv_en` is 0 from the next edge while it is the active code. Any other value allows the driver. In hardware mode the active code is `hw_cfg`.
- R6: In host mode the active code is the register, and `hw_cfg` has no effect. A write (`cfg_we`=1) at one edge stores `cfg_wdata`, and the stored value governs `drv_en` from the following edge. The register takes writes in either mode.
- R7: In hardware mode, `pd_a`=`pd_b`=1 at an edge makes `drv_en`, `aux_en` and `dio_en` 0 from that edge. Either control alone has no effect.
- R8: In host mode, `pd_a`=`pd_b`=1 makes `drv_en` and `aux_en` 0 while `dio_en` stays 1. Outside reset, `dio_en` is 1 whenever host mode is sampled.
- R9: Power-down does not clear the count. After release, `drv_en` returns on the next edge if `ref_present` has stayed high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock; all state is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_present | input | 1 | Reference clock detected, synchronous to tx_clk |
| host_mode | input | 1 | 1 = host mode, 0 = hardware mode |
| hw_cfg | input | 4 | Driver configuration code pins (hardware mode) |
| cfg_we | input | 1 | Write strobe for the host configuration register |
| cfg_wdata | input | 4 | Value written to the host configuration register |
| pd_a | input | 1 | Power-down control A |
| pd_b | input | 1 | Power-down control B |
| drv_en | output | 1 | Line driver enable (0 = high impedance) |
| aux_en | output | 1 | Enable for the other device outputs |
| dio_en | output | 1 | Enable for the processor-interface data outputs |

## Verification
Each result is due one `tx_clk` edge after the inputs that cause it are sampled. The driver-enable rise comes on the fourth reference-present edge itself. A register write affects `drv_en` one edge after the write edge. The driver task sets inputs 2 ns after a rising edge, works out the expected enables for the next edge and queues them with that edge's cycle number. The monitor compares at the falling edge once that cycle has arrived, so each comparison falls exactly at the latency given in the requirements.

// File: rtl/oe_pkg.sv
package oe_pkg;
    localparam int CFG_W      = 4;
    localparam int ARM_EDGES  = 4;
    localparam logic [CFG_W-1:0] HIZ_CODE = '1;

    typedef struct packed {
        logic drv;
        logic aux;
        logic dio;
    } oe_vec_t;
endpackage

// File: rtl/oe_arm_counter.sv
module oe_arm_counter #(
    parameter int ARM_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_present,
    output logic armed_next
);
    localparam int CNT_W = $clog2(ARM_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ARM_EDGES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } arm_st_t;

    arm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ref_present)
            st_d.cnt = '0;
        else if (st_q.cnt != CNT_MAX)
            st_d.cnt = st_q.cnt + 1'b1;
        armed_next = (st_d.cnt == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);
    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_present |=> st_q.cnt == '0);
endmodule

// File: rtl/oe_cfg_select.sv
module oe_cfg_select #(
    parameter int CFG_W = 4,
    parameter logic [CFG_W-1:0] HIZ_CODE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_mode,
    input  logic [CFG_W-1:0] hw_cfg,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] code_eff,
    output logic             code_ok
);
    typedef struct packed {
        logic [CFG_W-1:0] reg_code;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.reg_code = cfg_wdata;
        code_eff = host_mode ? st_q.reg_code : hw_cfg;
        code_ok  = (code_eff != HIZ_CODE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{reg_code: HIZ_CODE};
        else        st_q <= st_d;
    end

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q.reg_code));
endmodule

// File: rtl/oe_pd_policy.sv
module oe_pd_policy (
    input  logic            host_mode,
    input  logic            pd_a,
    input  logic            pd_b,
    input  logic            armed_next,
    input  logic            code_ok,
    output oe_pkg::oe_vec_t en_next
);
    logic pd_all;

    always_comb begin
        pd_all      = pd_a & pd_b;
        en_next.drv = armed_next & code_ok & ~pd_all;
        en_next.aux = ~pd_all;
        en_next.dio = host_mode | ~pd_all;
    end
endmodule

// File: rtl/line_oe_ctrl.sv
module line_oe_ctrl #(
    parameter int CFG_W     = oe_pkg::CFG_W,
    parameter int ARM_EDGES = oe_pkg::ARM_EDGES,
    parameter logic [CFG_W-1:0] HIZ_CODE = '1
) (
    input  logic             tx_clk,
    input  logic             rst_n,
    input  logic             ref_present,
    input  logic             host_mode,
    input  logic [CFG_W-1:0] hw_cfg,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             pd_a,
    input  logic             pd_b,
    output logic             drv_en,
    output logic             aux_en,
    output logic             dio_en
);
    logic             armed_next;
    logic             code_ok;
    logic [CFG_W-1:0] code_eff;
    oe_pkg::oe_vec_t  en_d, en_q;

    oe_arm_counter #(.ARM_EDGES(ARM_EDGES)) u_arm (
        .clk         (tx_clk),
        .rst_n       (rst_n),
        .ref_present (ref_present),
        .armed_next  (armed_next)
    );

    oe_cfg_select #(.CFG_W(CFG_W), .HIZ_CODE(HIZ_CODE)) u_cfg (
        .clk       (tx_clk),
        .rst_n     (rst_n),
        .host_mode (host_mode),
        .hw_cfg    (hw_cfg),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .code_eff  (code_eff),
        .code_ok   (code_ok)
    );

    oe_pd_policy u_pd (
        .host_mode  (host_mode),
        .pd_a       (pd_a),
        .pd_b       (pd_b),
        .armed_next (armed_next),
        .code_ok    (code_ok),
        .en_next    (en_d)
    );

    always_ff @(posedge tx_clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign drv_en = en_q.drv;
    assign aux_en = en_q.aux;
    assign dio_en = en_q.dio;

    p_drv_needs_ref_r2: assert property (@(posedge tx_clk) disable iff (!rst_n)
        drv_en |-> $past(ref_present));
    p_drv_code_r5: assert property (@(posedge tx_clk) disable iff (!rst_n)
        drv_en |-> $past(code_eff != HIZ_CODE));
    p_pd_off_r7: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (pd_a && pd_b) |=> (!drv_en && !aux_en));
    p_host_dio_r8: assert property (@(posedge tx_clk) disable iff (!rst_n)
        host_mode |=> dio_en);
    p_reset_off_r1: assert property (@(posedge tx_clk)
        !rst_n |-> (!drv_en && !aux_en && !dio_en));
endmodule

// File: tb/sim_line_oe_ctrl.sv
module sim_line_oe_ctrl;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       ref_present = 0, host_mode = 0, cfg_we = 0, pd_a = 0, pd_b = 0;
    logic [3:0] hw_cfg = 4'hF, cfg_wdata = 4'h0;
    logic       drv_en, aux_en, dio_en;

    int n_chk = 0, n_bad = 0, cyc_n = 0;
    int m_run = 0;
    logic [3:0] m_cfg = 4'hF;

    typedef struct { logic d; logic a; logic o; int due; } exp_t;
    exp_t  q[$];
    string tq[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    line_oe_ctrl u0 (
        .tx_clk(clk), .rst_n(rst_n), .ref_present(ref_present), .host_mode(host_mode),
        .hw_cfg(hw_cfg), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pd_a(pd_a), .pd_b(pd_b),
        .drv_en(drv_en), .aux_en(aux_en), .dio_en(dio_en)
    );

    task automatic check3(string tag, logic d, logic a, logic o);
        n_chk++;
        if (drv_en !== d || aux_en !== a || dio_en !== o) begin
            n_bad++;
            $display("FAIL %s: got drv/aux/dio=%b%b%b expected %b%b%b", tag,
                     drv_en, aux_en, dio_en, d, a, o);
        end
    endtask

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc_n) begin
            exp_t e;
            string t;
            e = q.pop_front();
            t = tq.pop_front();
            check3(t, e.d, e.a, e.o);
        end
    end

    // Drive one cycle of inputs and queue the enables due after the next edge.
    task automatic step(string tag, logic rf, logic hm, logic [3:0] hc,
                        logic we, logic [3:0] wd, logic pa, logic pb);
        exp_t e;
        logic [3:0] code;
        logic pd;
        ref_present = rf; host_mode = hm; hw_cfg = hc;
        cfg_we = we; cfg_wdata = wd; pd_a = pa; pd_b = pb;
        code  = hm ? m_cfg : hc;
        m_run = rf ? ((m_run < 4) ? m_run + 1 : 4) : 0;
        pd    = pa & pb;
        e.d   = (m_run == 4) && (code != 4'hF) && !pd;
        e.a   = !pd;
        e.o   = hm || !pd;
        e.due = cyc_n + 1;
        if (we) m_cfg = wd;
        q.push_back(e);
        tq.push_back(tag);
        @(posedge clk); #2;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2;
        m_run = 0; m_cfg = 4'hF;
        check3("R1 reset", 0, 0, 0);
        rst_n = 1;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R6/R1: host mode, register still at reset code, driver stays off
        repeat (6) step("R6 reset code blocks", 1, 1, 4'h3, 0, 0, 0, 0);
        step("R3 ref lost", 0, 0, 4'h3, 0, 0, 0, 0);
        // R2: hardware mode arming
        repeat (3) step("R2 before 4th edge", 1, 0, 4'h3, 0, 0, 0, 0);
        step("R2 4th edge", 1, 0, 4'h3, 0, 0, 0, 0);
        repeat (10) step("R4 saturate", 1, 0, 4'h3, 0, 0, 0, 0);
        // R3: loss and re-arm
        step("R3 ref drop", 0, 0, 4'h3, 0, 0, 0, 0);
        repeat (4) step("R3 rearm", 1, 0, 4'h3, 0, 0, 0, 0);
        // R5: hi-Z code on pins
        step("R5 hiz code", 1, 0, 4'hF, 0, 0, 0, 0);
        step("R5 code 0", 1, 0, 4'h0, 0, 0, 0, 0);
        step("R5 code E", 1, 0, 4'hE, 0, 0, 0, 0);
        // R7: power-down in hardware mode
        step("R7 pd_a only", 1, 0, 4'h5, 0, 0, 1, 0);
        step("R7 pd_b only", 1, 0, 4'h5, 0, 0, 0, 1);
        repeat (3) step("R7 pd both hw", 1, 0, 4'h5, 0, 0, 1, 1);
        step("R9 pd release", 1, 0, 4'h5, 0, 0, 0, 0);
        // R6: host register
        step("R6 host reg hiz", 1, 1, 4'h5, 0, 0, 0, 0);
        step("R6 write edge", 1, 1, 4'h5, 1, 4'h7, 0, 0);
        step("R6 after write", 1, 1, 4'hF, 0, 0, 0, 0);
        step("R6 pins ignored", 1, 1, 4'hF, 0, 0, 0, 0);
        // R8: power-down in host mode
        repeat (2) step("R8 pd both host", 1, 1, 4'hF, 0, 0, 1, 1);
        step("R9 host release", 1, 1, 4'hF, 0, 0, 0, 0);
        step("R6 write hiz", 1, 1, 4'h2, 1, 4'hF, 0, 0);
        step("R6 hiz stored", 1, 1, 4'h2, 0, 0, 0, 0);
        step("R6 write in hw mode", 1, 0, 4'h2, 1, 4'h9, 0, 0);
        step("R6 host uses 9", 1, 1, 4'hF, 0, 0, 0, 0);
        repeat (2) step("R9 pd with ref low", 0, 0, 4'h2, 0, 0, 1, 1);
        // R1: reset mid-run restores the hi-Z register
        step("R1 pre-reset", 1, 1, 4'h2, 0, 0, 0, 0);
        @(posedge clk); #2;
        @(posedge clk); #2;
        do_reset();
        repeat (6) step("R1 register back to hiz", 1, 1, 4'h2, 0, 0, 0, 0);
        @(posedge clk); #2;
        @(posedge clk); #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule